// File: doc/BRIEF.md
# Speculative Coalescing Store Buffer

This block sits between a core's retirement stage and its primary data cache. It keeps store data only while the cache miss for that store's block is outstanding. Each entry covers one whole cache block. An entry holds the block address, a per-byte valid mask, the byte data and a flag that marks the content as speculative. Stores to a block that is already buffered fold into its entry. Stores to a new block take a free entry and send a miss request that names the entry. The number of entries matches the number of misses that may be in flight at once, so the storage does not depend on how deep speculation runs.

When the response for an entry arrives, the entry writes its bytes into the data cache through a single write port. It also reports whether the bytes are speculative, so the cache can set that block's written bit. Loads look up the buffer by block address and receive the bytes held there. An abort throws away every speculative entry. A commit turns every speculative entry into a normal one.

A speculative entry whose miss is still outstanding at abort time keeps its slot until the response returns. This way a response can never land on an entry that has since been reused. The coherence protocol, the cache arrays and the next cache level are outside the block and are seen only through the request, response and write ports.

Top module: `spec_store_coalescer`

## Requirements
- R1: After reset the buffer is empty: `sb_full`, `ld_hit`, `miss_req_valid` and `dc_wr_valid` are all 0, and `ld_mask` is 0.
- R2: A store to a block not present in the buffer is accepted when an entry is free. It takes the free entry with the lowest index and, in the same cycle, raises `miss_req_valid` with `miss_req_id` equal to that index and `miss_req_addr` equal to the store's block address.
- R3: A store to a block already present with the same speculative flag is accepted without a miss request. Its `st_mask` bits are ORed into the entry's mask, and its masked bytes replace the older ones (byte k of `st_data` is bits 8k+7..8k, enabled by `st_mask[k]`).
- R4: A load whose block address matches a present entry sees `ld_hit`=1, the accumulated byte mask on `ld_mask`, and the held bytes on `ld_data`, with zero in bytes that are not valid. A store is visible to loads from the cycle after it is accepted. A load to an absent block sees `ld_hit`=0 and a zero mask.
- R5: When all entries are occupied, including discarded entries that still await a response, `sb_full` is 1 and a store to a new block is not accepted. A store that merges into a present entry is still accepted.
- R6: A response on bit i of `fill_valid` makes entry i ready. From the next cycle, ready entries write to the cache one per cycle, lowest index first. Each write presents the entry's address, mask, data and speculative flag on the `dc_wr_*` ports, and the entry is freed after the write.
- R7: A store whose block is present with a different speculative flag is not accepted (`st_ready`=0) until that entry is gone.
- R8: An abort removes every speculative entry. From the next cycle loads miss on them. A ready speculative entry never writes to the cache, not even in the abort cycle. A pending speculative entry keeps its index occupied until its response arrives and is then freed without a cache write.
- R9: A commit clears the speculative flag of every present entry. Later writes of those entries show `dc_wr_spec`=0, and normal stores may then merge into them.
- R10: No store is accepted in a cycle where `spec_abort` or `spec_commit` is 1.
- R11: A store whose block entry is writing to the cache in that cycle is not accepted. The block's entry is free in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spec_abort | input | 1 | Discard all speculative content |
| spec_commit | input | 1 | Make all speculative content normal |
| st_valid | input | 1 | Retired store offered |
| st_addr | input | BLK_ADDR_W (26) | Store block address |
| st_mask | input | BLK_BYTES (16) | Store byte enables |
| st_data | input | 8*BLK_BYTES (128) | Store bytes |
| st_spec | input | 1 | Store is speculative |
| st_ready | output | 1 | Store accepted this cycle when st_valid is 1 |
| sb_full | output | 1 | No entry free |
| ld_addr | input | BLK_ADDR_W (26) | Load lookup block address |
| ld_hit | output | 1 | Block present in buffer |
| ld_mask | output | BLK_BYTES (16) | Valid bytes of the present block |
| ld_data | output | 8*BLK_BYTES (128) | Buffered bytes, zero where not valid |
| miss_req_valid | output | 1 | Miss request for a newly allocated entry |
| miss_req_id | output | log2(N_ENT) (3) | Entry index carried by the request |
| miss_req_addr | output | BLK_ADDR_W (26) | Block address of the request |
| fill_valid | input | N_ENT (8) | Response arrived for entry i (bit i) |
| dc_wr_valid | output | 1 | Cache write of one drained entry |
| dc_wr_addr | output | BLK_ADDR_W (26) | Block address written |
| dc_wr_mask | output | BLK_BYTES (16) | Bytes written |
| dc_wr_data | output | 8*BLK_BYTES (128) | Data written |
| dc_wr_spec | output | 1 | Written bytes are speculative (set the block's written bit) |

## Verification
The properties assume a well-behaved environment. A response arrives only for an entry that has a miss outstanding, at most once per request, and the cache accepts every write in the cycle it is presented. The directed stimulus respects this. Each test records the entry index from each miss request and sends responses only for those indices. Responses for discarded entries arrive after the abort, and every test ends with the buffer drained, so the next test starts from an empty set of indices.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   typedef enum logic [1:0] {
      E_IDLE   = 2'd0,
      E_PEND   = 2'd1,
      E_READY  = 2'd2,
      E_ORPHAN = 2'd3
   } ent_state_e;
endpackage

// File: rtl/sbuf_pick.sv
module sbuf_pick #(
   parameter int N         = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  gnt_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         gnt_o = '0;
         idx_o = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
               gnt_o = '0;
               gnt_o[i] = 1'b1;
               idx_o = IW'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         gnt_o = '0;
         idx_o = '0;
         for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
               gnt_o = '0;
               gnt_o[i] = 1'b1;
               idx_o = IW'(i);
            end
         end
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/sbuf_match.sv
module sbuf_match #(
   parameter int N  = 8,
   parameter int AW = 26
) (
   input  logic [AW-1:0]         key_i,
   input  logic [N-1:0][AW-1:0]  addr_i,
   input  logic [N-1:0]          live_i,
   output logic [N-1:0]          hit_o
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_o[i] = live_i[i] && (addr_i[i] == key_i);
   end
endmodule

// File: rtl/sbuf_entry.sv
module sbuf_entry
   import sbuf_pkg::*;
#(
   parameter int AW    = 26,
   parameter int BYTES = 16,
   localparam int DW   = BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic             merge_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [BYTES-1:0] wr_mask_i,
   input  logic [DW-1:0]    wr_data_i,
   input  logic             wr_spec_i,
   input  logic             fill_i,
   input  logic             drain_i,
   input  logic             abort_i,
   input  logic             commit_i,
   output ent_state_e       state_o,
   output logic [AW-1:0]    addr_o,
   output logic [BYTES-1:0] mask_o,
   output logic [DW-1:0]    data_o,
   output logic             spec_o
);
   ent_state_e       state_q;
   logic [AW-1:0]    addr_q;
   logic [BYTES-1:0] mask_q;
   logic [DW-1:0]    data_q;
   logic             spec_q;
   logic [DW-1:0]    fresh_data;
   logic [DW-1:0]    folded_data;
   logic             present;

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign fresh_data[b*8 +: 8]  = wr_mask_i[b] ? wr_data_i[b*8 +: 8] : 8'h00;
      assign folded_data[b*8 +: 8] = wr_mask_i[b] ? wr_data_i[b*8 +: 8] : data_q[b*8 +: 8];
   end

   assign present = (state_q == E_PEND) || (state_q == E_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= E_IDLE;
         addr_q  <= '0;
         mask_q  <= '0;
         data_q  <= '0;
         spec_q  <= 1'b0;
      end else begin
         case (state_q)
            E_IDLE: begin
               if (alloc_i) begin
                  state_q <= E_PEND;
                  addr_q  <= wr_addr_i;
                  mask_q  <= wr_mask_i;
                  data_q  <= fresh_data;
                  spec_q  <= wr_spec_i;
               end
            end
            E_PEND: begin
               if (abort_i && spec_q) begin
                  state_q <= fill_i ? E_IDLE : E_ORPHAN;
               end else if (fill_i) begin
                  state_q <= E_READY;
               end
            end
            E_READY: begin
               if ((abort_i && spec_q) || drain_i) begin
                  state_q <= E_IDLE;
               end
            end
            E_ORPHAN: begin
               if (fill_i) begin
                  state_q <= E_IDLE;
               end
            end
            default: state_q <= E_IDLE;
         endcase
         if (merge_i && present) begin
            mask_q <= mask_q | wr_mask_i;
            data_q <= folded_data;
         end
         if (commit_i && present && !abort_i) begin
            spec_q <= 1'b0;
         end
      end
   end

   assign state_o = state_q;
   assign addr_o  = addr_q;
   assign mask_o  = mask_q;
   assign data_o  = data_q;
   assign spec_o  = spec_q;
endmodule

// File: rtl/spec_store_coalescer.sv
module spec_store_coalescer
   import sbuf_pkg::*;
#(
   parameter int N_ENT      = 8,
   parameter int BLK_ADDR_W = 26,
   parameter int BLK_BYTES  = 16,
   localparam int DATA_W    = BLK_BYTES * 8,
   localparam int ID_W      = $clog2(N_ENT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  spec_abort,
   input  logic                  spec_commit,
   input  logic                  st_valid,
   input  logic [BLK_ADDR_W-1:0] st_addr,
   input  logic [BLK_BYTES-1:0]  st_mask,
   input  logic [DATA_W-1:0]     st_data,
   input  logic                  st_spec,
   output logic                  st_ready,
   output logic                  sb_full,
   input  logic [BLK_ADDR_W-1:0] ld_addr,
   output logic                  ld_hit,
   output logic [BLK_BYTES-1:0]  ld_mask,
   output logic [DATA_W-1:0]     ld_data,
   output logic                  miss_req_valid,
   output logic [ID_W-1:0]       miss_req_id,
   output logic [BLK_ADDR_W-1:0] miss_req_addr,
   input  logic [N_ENT-1:0]      fill_valid,
   output logic                  dc_wr_valid,
   output logic [BLK_ADDR_W-1:0] dc_wr_addr,
   output logic [BLK_BYTES-1:0]  dc_wr_mask,
   output logic [DATA_W-1:0]     dc_wr_data,
   output logic                  dc_wr_spec
);
   if (N_ENT < 2) begin : g_bad_depth
      $error("spec_store_coalescer: N_ENT must be at least 2");
   end
   if ((BLK_BYTES < 4) || ((BLK_BYTES & (BLK_BYTES - 1)) != 0)) begin : g_bad_block
      $error("spec_store_coalescer: BLK_BYTES must be a power of two, at least 4");
   end
   if (BLK_ADDR_W < 1) begin : g_bad_addr
      $error("spec_store_coalescer: BLK_ADDR_W must be positive");
   end

   ent_state_e                        ent_state [N_ENT];
   logic [N_ENT-1:0][BLK_ADDR_W-1:0]  ent_addr;
   logic [N_ENT-1:0][BLK_BYTES-1:0]   ent_mask;
   logic [N_ENT-1:0][DATA_W-1:0]      ent_data;
   logic [N_ENT-1:0]                  ent_spec;
   logic [N_ENT-1:0]                  ent_live;
   logic [N_ENT-1:0]                  ent_free;
   logic [N_ENT-1:0]                  ent_drainable;

   logic [N_ENT-1:0] st_hit_vec;
   logic [N_ENT-1:0] ld_hit_vec;
   logic [N_ENT-1:0] alloc_oh;
   logic [N_ENT-1:0] drain_oh;
   logic [ID_W-1:0]  alloc_idx;
   logic [ID_W-1:0]  drain_idx;
   logic             free_any;
   logic             drain_any;

   logic st_hit_any;
   logic st_hit_spec;
   logic st_class_clash;
   logic st_drain_clash;
   logic hold_off;
   logic accept;
   logic do_alloc;
   logic do_merge;

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      sbuf_entry #(
         .AW    (BLK_ADDR_W),
         .BYTES (BLK_BYTES)
      ) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_i   (do_alloc && alloc_oh[i]),
         .merge_i   (do_merge && st_hit_vec[i]),
         .wr_addr_i (st_addr),
         .wr_mask_i (st_mask),
         .wr_data_i (st_data),
         .wr_spec_i (st_spec),
         .fill_i    (fill_valid[i]),
         .drain_i   (drain_oh[i]),
         .abort_i   (spec_abort),
         .commit_i  (spec_commit),
         .state_o   (ent_state[i]),
         .addr_o    (ent_addr[i]),
         .mask_o    (ent_mask[i]),
         .data_o    (ent_data[i]),
         .spec_o    (ent_spec[i])
      );
      assign ent_live[i]      = (ent_state[i] == E_PEND) || (ent_state[i] == E_READY);
      assign ent_free[i]      = (ent_state[i] == E_IDLE);
      assign ent_drainable[i] = (ent_state[i] == E_READY) && !(spec_abort && ent_spec[i]);
   end

   sbuf_pick #(.N(N_ENT), .LOW_FIRST(1'b1)) u_free_pick (
      .req_i (ent_free),
      .gnt_o (alloc_oh),
      .idx_o (alloc_idx),
      .any_o (free_any)
   );

   sbuf_pick #(.N(N_ENT), .LOW_FIRST(1'b1)) u_drain_pick (
      .req_i (ent_drainable),
      .gnt_o (drain_oh),
      .idx_o (drain_idx),
      .any_o (drain_any)
   );

   sbuf_match #(.N(N_ENT), .AW(BLK_ADDR_W)) u_st_match (
      .key_i  (st_addr),
      .addr_i (ent_addr),
      .live_i (ent_live),
      .hit_o  (st_hit_vec)
   );

   sbuf_match #(.N(N_ENT), .AW(BLK_ADDR_W)) u_ld_match (
      .key_i  (ld_addr),
      .addr_i (ent_addr),
      .live_i (ent_live),
      .hit_o  (ld_hit_vec)
   );

   // store admission
   assign st_hit_any     = |st_hit_vec;
   assign st_hit_spec    = |(st_hit_vec & ent_spec);
   assign st_class_clash = st_hit_any && (st_hit_spec != st_spec);
   assign st_drain_clash = |(st_hit_vec & drain_oh);
   assign hold_off       = spec_abort || spec_commit;

   always_comb begin
      if (hold_off) begin
         st_ready = 1'b0;
      end else if (st_hit_any) begin
         st_ready = !st_class_clash && !st_drain_clash;
      end else begin
         st_ready = free_any;
      end
   end

   assign accept   = st_valid && st_ready;
   assign do_alloc = accept && !st_hit_any;
   assign do_merge = accept && st_hit_any;
   assign sb_full  = !free_any;

   assign miss_req_valid = do_alloc;
   assign miss_req_id    = alloc_idx;
   assign miss_req_addr  = st_addr;

   // load forwarding: at most one live entry per block
   always_comb begin
      ld_mask = '0;
      ld_data = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (ld_hit_vec[i]) begin
            ld_mask = ld_mask | ent_mask[i];
            ld_data = ld_data | ent_data[i];
         end
      end
   end
   assign ld_hit = |ld_hit_vec;

   // drain into the primary cache
   assign dc_wr_valid = drain_any;
   assign dc_wr_addr  = ent_addr[drain_idx];
   assign dc_wr_mask  = ent_mask[drain_idx];
   assign dc_wr_data  = ent_data[drain_idx];
   assign dc_wr_spec  = drain_any && ent_spec[drain_idx] && !spec_commit;
endmodule

// File: rtl/spec_store_coalescer_chk.sv
module spec_store_coalescer_chk #(
   parameter int N_ENT      = 8,
   parameter int BLK_ADDR_W = 26,
   parameter int BLK_BYTES  = 16,
   localparam int DATA_W    = BLK_BYTES * 8,
   localparam int ID_W      = $clog2(N_ENT)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  spec_abort,
   input logic                  spec_commit,
   input logic                  st_valid,
   input logic [BLK_ADDR_W-1:0] st_addr,
   input logic [BLK_BYTES-1:0]  st_mask,
   input logic [DATA_W-1:0]     st_data,
   input logic                  st_spec,
   input logic                  st_ready,
   input logic                  sb_full,
   input logic [BLK_ADDR_W-1:0] ld_addr,
   input logic                  ld_hit,
   input logic [BLK_BYTES-1:0]  ld_mask,
   input logic [DATA_W-1:0]     ld_data,
   input logic                  miss_req_valid,
   input logic [ID_W-1:0]       miss_req_id,
   input logic [BLK_ADDR_W-1:0] miss_req_addr,
   input logic [N_ENT-1:0]      fill_valid,
   input logic                  dc_wr_valid,
   input logic [BLK_ADDR_W-1:0] dc_wr_addr,
   input logic [BLK_BYTES-1:0]  dc_wr_mask,
   input logic [DATA_W-1:0]     dc_wr_data,
   input logic                  dc_wr_spec
);
   // R2: a miss request only goes out for an accepted store
   p_req_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req_valid |-> (st_valid && st_ready && (miss_req_addr == st_addr)));

   // R5: no allocation while every entry is occupied
   p_full_no_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sb_full |-> !miss_req_valid);

   // R4: an absent block forwards no valid bytes
   p_ld_miss_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_hit |-> (ld_mask == '0));

   // R8: aborted speculative data never reaches the cache
   p_abort_no_spec_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spec_abort |-> !(dc_wr_valid && dc_wr_spec));

   // R9: after a commit no speculative content remains
   p_commit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      spec_commit |=> !(dc_wr_valid && dc_wr_spec));

   // R10: stores are held off during abort and commit
   p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (spec_abort || spec_commit) |-> !st_ready);
endmodule

bind spec_store_coalescer spec_store_coalescer_chk #(
   .N_ENT      (N_ENT),
   .BLK_ADDR_W (BLK_ADDR_W),
   .BLK_BYTES  (BLK_BYTES)
) u_chk (.*);

// File: tb/tb_spec_store_coalescer.sv
`timescale 1ns/1ps
module tb_spec_store_coalescer;
   localparam int N   = 8;
   localparam int AW  = 26;
   localparam int NB  = 16;
   localparam int DW  = NB * 8;
   localparam int IW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          spec_abort = 1'b0;
   logic          spec_commit = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [NB-1:0] st_mask = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_spec = 1'b0;
   logic          st_ready;
   logic          sb_full;
   logic [AW-1:0] ld_addr = '0;
   logic          ld_hit;
   logic [NB-1:0] ld_mask;
   logic [DW-1:0] ld_data;
   logic          miss_req_valid;
   logic [IW-1:0] miss_req_id;
   logic [AW-1:0] miss_req_addr;
   logic [N-1:0]  fill_valid = '0;
   logic          dc_wr_valid;
   logic [AW-1:0] dc_wr_addr;
   logic [NB-1:0] dc_wr_mask;
   logic [DW-1:0] dc_wr_data;
   logic          dc_wr_spec;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   // sampled outputs of the last step
   logic          s_ready, s_full, s_req, s_ldhit, s_dcv, s_dcs;
   logic [IW-1:0] s_rid;
   logic [AW-1:0] s_raddr, s_dca;
   logic [NB-1:0] s_ldmask, s_dcm;
   logic [DW-1:0] s_lddata, s_dcd;

   always #2.5 clk = ~clk;

   spec_store_coalescer dut (
      .clk(clk), .rst_n(rst_n), .spec_abort(spec_abort), .spec_commit(spec_commit),
      .st_valid(st_valid), .st_addr(st_addr), .st_mask(st_mask), .st_data(st_data),
      .st_spec(st_spec), .st_ready(st_ready), .sb_full(sb_full),
      .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_mask(ld_mask), .ld_data(ld_data),
      .miss_req_valid(miss_req_valid), .miss_req_id(miss_req_id), .miss_req_addr(miss_req_addr),
      .fill_valid(fill_valid), .dc_wr_valid(dc_wr_valid), .dc_wr_addr(dc_wr_addr),
      .dc_wr_mask(dc_wr_mask), .dc_wr_data(dc_wr_data), .dc_wr_spec(dc_wr_spec)
   );

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic sv, input logic [AW-1:0] sa, input logic [NB-1:0] sm,
                       input logic [DW-1:0] sd, input logic ss, input logic ab,
                       input logic cm, input logic [N-1:0] fv, input logic [AW-1:0] la);
      @(negedge clk);
      st_valid = sv; st_addr = sa; st_mask = sm; st_data = sd; st_spec = ss;
      spec_abort = ab; spec_commit = cm; fill_valid = fv; ld_addr = la;
      #1;
      s_ready = st_ready; s_full = sb_full; s_req = miss_req_valid;
      s_rid = miss_req_id; s_raddr = miss_req_addr;
      s_ldhit = ld_hit; s_ldmask = ld_mask; s_lddata = ld_data;
      s_dcv = dc_wr_valid; s_dca = dc_wr_addr; s_dcm = dc_wr_mask;
      s_dcd = dc_wr_data; s_dcs = dc_wr_spec;
      @(posedge clk);
      #1;
      st_valid = 1'b0; spec_abort = 1'b0; spec_commit = 1'b0; fill_valid = '0;
   endtask

   task automatic put(input logic [AW-1:0] a, input logic [NB-1:0] m,
                      input logic [DW-1:0] d, input logic s);
      step(1'b1, a, m, d, s, 1'b0, 1'b0, '0, '0);
   endtask

   task automatic idle(input logic [AW-1:0] la);
      step(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, '0, la);
   endtask

   task automatic fill(input logic [N-1:0] fv);
      step(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, fv, '0);
   endtask

   task automatic t_reset;
      idle(26'h0);
      chk("R1", "full", DW'(s_full), 0);
      chk("R1", "ld_hit", DW'(s_ldhit), 0);
      chk("R1", "ld_mask", DW'(s_ldmask), 0);
      chk("R1", "req", DW'(s_req), 0);
      chk("R1", "dc_valid", DW'(s_dcv), 0);
   endtask

   task automatic t_alloc_merge;
      put(26'h0A0, 16'h000F, 128'h44332211, 1'b0);
      chk("R2", "A accept", DW'(s_ready), 1);
      chk("R2", "A req", DW'(s_req), 1);
      chk("R2", "A id", DW'(s_rid), 0);
      chk("R2", "A addr", DW'(s_raddr), 26'h0A0);
      put(26'h0B0, 16'h0001, 128'h77, 1'b0);
      chk("R2", "B id", DW'(s_rid), 1);
      put(26'h0A0, 16'h0030, 128'h0000_6655_0000_0000, 1'b0);
      chk("R3", "merge accept", DW'(s_ready), 1);
      chk("R3", "merge no req", DW'(s_req), 0);
      put(26'h0A0, 16'h0003, 128'hBBAA, 1'b0);
      chk("R3", "overwrite no req", DW'(s_req), 0);
      idle(26'h0A0);
      chk("R4", "ld hit", DW'(s_ldhit), 1);
      chk("R3", "ld mask", DW'(s_ldmask), 16'h003F);
      chk("R4", "ld data", s_lddata, 128'h0000_6655_4433_BBAA);
      idle(26'h0C0);
      chk("R4", "absent hit", DW'(s_ldhit), 0);
      chk("R4", "absent mask", DW'(s_ldmask), 0);
      fill(8'b0000_0011);
      idle(26'h0);
      chk("R6", "first drain valid", DW'(s_dcv), 1);
      chk("R6", "first drain addr", DW'(s_dca), 26'h0A0);
      chk("R6", "first drain mask", DW'(s_dcm), 16'h003F);
      chk("R6", "first drain data", s_dcd, 128'h0000_6655_4433_BBAA);
      chk("R6", "first drain spec", DW'(s_dcs), 0);
      idle(26'h0A0);
      chk("R6", "second drain addr", DW'(s_dca), 26'h0B0);
      chk("R6", "A freed", DW'(s_ldhit), 0);
      idle(26'h0);
      chk("R6", "drained out", DW'(s_dcv), 0);
   endtask

   task automatic t_full;
      for (int i = 0; i < N; i++) begin
         put(26'h100 + AW'(i), NB'(1) << i, DW'(8'h10 + i) << (8 * i), 1'b0);
         chk("R2", "fill-up id", DW'(s_rid), DW'(i));
      end
      put(26'h200, 16'h0001, 128'h1, 1'b0);
      chk("R5", "full flag", DW'(s_full), 1);
      chk("R5", "new block refused", DW'(s_ready), 0);
      chk("R5", "no req when full", DW'(s_req), 0);
      put(26'h103, 16'h8000, DW'(8'hEE) << 120, 1'b0);
      chk("R5", "merge when full", DW'(s_ready), 1);
      fill(8'hFF);
      for (int k = 0; k < N; k++) begin
         idle(26'h0);
         chk("R6", "order valid", DW'(s_dcv), 1);
         chk("R6", "order addr", DW'(s_dca), DW'(26'h100 + k));
         if (k == 3) begin
            chk("R5", "merged mask", DW'(s_dcm), 16'h8008);
            chk("R5", "merged data", s_dcd, (DW'(8'hEE) << 120) | (DW'(8'h13) << 24));
         end
      end
      idle(26'h0);
      chk("R5", "not full after drain", DW'(s_full), 0);
      chk("R6", "no drain left", DW'(s_dcv), 0);
   endtask

   task automatic t_conflict;
      put(26'h300, 16'h0001, 128'h01, 1'b1);
      chk("R2", "spec alloc id", DW'(s_rid), 0);
      put(26'h300, 16'h0002, 128'h0200, 1'b0);
      chk("R7", "normal into spec refused", DW'(s_ready), 0);
      put(26'h310, 16'h0001, 128'h05, 1'b0);
      chk("R2", "normal alloc id", DW'(s_rid), 1);
      put(26'h310, 16'h0002, 128'h0600, 1'b1);
      chk("R7", "spec into normal refused", DW'(s_ready), 0);
      put(26'h300, 16'h0004, 128'h030000, 1'b1);
      chk("R3", "spec merge accept", DW'(s_ready), 1);
      chk("R3", "spec merge no req", DW'(s_req), 0);
      fill(8'b0000_0011);
      idle(26'h0);
      chk("R6", "spec drain flag", DW'(s_dcs), 1);
      chk("R6", "spec drain mask", DW'(s_dcm), 16'h0005);
      idle(26'h0);
      chk("R6", "normal drain flag", DW'(s_dcs), 0);
      chk("R6", "normal drain addr", DW'(s_dca), 26'h310);
   endtask

   task automatic t_abort;
      put(26'h400, 16'h0001, 128'h1, 1'b1);
      chk("R2", "K id", DW'(s_rid), 0);
      put(26'h410, 16'h0001, 128'h2, 1'b1);
      chk("R2", "L id", DW'(s_rid), 1);
      put(26'h420, 16'h0001, 128'h3, 1'b0);
      chk("R2", "M id", DW'(s_rid), 2);
      fill(8'b0000_0010);
      step(1'b1, 26'h430, 16'h0001, 128'h4, 1'b0, 1'b1, 1'b0, '0, 26'h0);
      chk("R8", "ready spec not written", DW'(s_dcv), 0);
      chk("R10", "store refused in abort", DW'(s_ready), 0);
      idle(26'h400);
      chk("R8", "pending spec gone", DW'(s_ldhit), 0);
      idle(26'h410);
      chk("R8", "ready spec gone", DW'(s_ldhit), 0);
      idle(26'h420);
      chk("R8", "normal kept", DW'(s_ldhit), 1);
      put(26'h430, 16'h0001, 128'h4, 1'b0);
      chk("R8", "orphan slot skipped", DW'(s_rid), 1);
      fill(8'b0000_0001);
      put(26'h440, 16'h0001, 128'h5, 1'b0);
      chk("R8", "orphan freed silently", DW'(s_dcv), 0);
      chk("R8", "orphan slot reused", DW'(s_rid), 0);
      fill(8'b0000_0111);
      idle(26'h0);
      chk("R6", "after abort drain 0", DW'(s_dca), 26'h440);
      idle(26'h0);
      chk("R6", "after abort drain 1", DW'(s_dca), 26'h430);
      idle(26'h0);
      chk("R6", "after abort drain 2", DW'(s_dca), 26'h420);
      chk("R8", "normal drain flag", DW'(s_dcs), 0);
   endtask

   task automatic t_commit;
      put(26'h500, 16'h0F00, 128'hDDCC_BBAA << 64, 1'b1);
      chk("R2", "Q id", DW'(s_rid), 0);
      step(1'b1, 26'h510, 16'h0001, 128'h1, 1'b0, 1'b0, 1'b1, '0, 26'h0);
      chk("R10", "store refused in commit", DW'(s_ready), 0);
      put(26'h500, 16'hF000, 128'h1122_3344 << 96, 1'b0);
      chk("R9", "normal merge after commit", DW'(s_ready), 1);
      chk("R9", "no req on merge", DW'(s_req), 0);
      fill(8'b0000_0001);
      idle(26'h0);
      chk("R9", "committed drain flag", DW'(s_dcs), 0);
      chk("R9", "committed drain mask", DW'(s_dcm), 16'hFF00);
      chk("R9", "committed drain data", s_dcd, (128'h1122_3344 << 96) | (128'hDDCC_BBAA << 64));
   endtask

   task automatic t_collide;
      put(26'h600, 16'h0001, 128'h9, 1'b0);
      chk("R2", "S id", DW'(s_rid), 0);
      fill(8'b0000_0001);
      put(26'h600, 16'h0002, 128'h0900, 1'b0);
      chk("R11", "draining block refused", DW'(s_ready), 0);
      chk("R11", "drain under way", DW'(s_dcv), 1);
      put(26'h600, 16'h0002, 128'h0900, 1'b0);
      chk("R11", "later store accepted", DW'(s_ready), 1);
      chk("R11", "later store new miss", DW'(s_req), 1);
      chk("R11", "later store id", DW'(s_rid), 0);
      fill(8'b0000_0001);
      idle(26'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_alloc_merge;
      t_full;
      t_conflict;
      t_abort;
      t_commit;
      t_collide;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule